// File: doc/BRIEF.md
# Interleaved PLL control word writer

This block builds the 24-bit serial-load control word for a clock synthesizer from its individual fields. The fields are the feedback divider, the reference divider, the prescale select, two output dividers, two output enables, a clock source select and two reserved bits. It then delivers that word as a framed burst of nine register writes. Each write carries a 32-bit data value and a 16-bit control value. The control word is carried four bits per write, and each bit sits in the lowest bit of its own byte lane.

A start pulse seen while the block is idle captures all field inputs. On the next nine clock cycles the block issues one write strobe per cycle. `busy` is high for those nine cycles. `done` pulses for one cycle after the last write. The reserved bits are always set to their required values, whatever the inputs are.

Top module: `pllw_writer`

## Requirements
- R1: The control word layout is: feedback divider at bits 6:0, reference divider at 13:7, prescale select at 14 (0 = divide by 1, 1 = divide by 8), divided-clock divider at 16:15, VCO output divider at 18:17, clock output enable at 19, divided-clock output enable at 20, clock source select at 22.
- R2: Word bit 21 is always 0 and word bit 23 is always 1, whatever values are on `rsv_lo_in` and `rsv_hi_in`.
- R3: A start pulse sampled while idle produces exactly 9 write strobes on 9 consecutive cycles, beginning on the cycle after the sampling edge.
- R4: Write 0 carries control 0xF800 and write 1 carries control 0xF000, both with data 0.
- R5: Write 2+k (k = 0..5) carries control 0x0000. Word bits 4k, 4k+1, 4k+2 and 4k+3 go to data bits 0, 8, 16 and 24, and every other data bit is 0.
- R6: Write 8 carries control 0xF800 with data 0.
- R7: `busy` is high exactly during the strobe cycles. `done` is high for one cycle, on the cycle after the last strobe.
- R8: A start pulse, or a change of the field inputs, during a sequence has no effect: the sequence stays as captured and no further strobe follows `done`.
- R9: After reset, and whenever idle, `wr_stb`, `busy` and `done` are 0 and `wr_data` and `wr_ctrl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| fb_div | input | 7 | Feedback divider field |
| ref_div | input | 7 | Reference divider field |
| pre_sel | input | 1 | Prescale select (0 = /1, 1 = /8) |
| xdiv | input | 2 | Divided-clock output divider |
| vco_div | input | 2 | VCO output divider |
| clk_oe | input | 1 | Clock output enable |
| clkx_oe | input | 1 | Divided-clock output enable |
| rsv_lo_in | input | 1 | Reserved input, forced to 0 in the word |
| src_sel | input | 1 | Clock source select |
| rsv_hi_in | input | 1 | Reserved input, forced to 1 in the word |
| wr_stb | output | 1 | Write strobe, one per write |
| wr_data | output | 32 | Write data value |
| wr_ctrl | output | 16 | Write control/address value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A walking-one pattern over all 24 field bit positions shows that each input bit lands in exactly one write and one byte lane. When the walking bit is one of the two reserved inputs, it also shows that those inputs never reach the output. All-zero and all-one inputs, plus an arithmetic sweep of dense patterns, separate nibble-order faults from lane-order faults. The all-zero pattern shows the forced reserved-high bit in isolation. A run that pulses start again and inverts every field in mid-sequence tells a design that recaptures or restarts apart from one that holds its captured word.

// File: rtl/pllw_pkg.sv
// Shared constants and the control-word layout for the PLL word writer.
package pllw_pkg;
    localparam int WORD_W      = 24;
    localparam int NIB_W       = 4;
    localparam int NIB_CNT     = WORD_W / NIB_W;
    localparam int DATA_W      = 32;
    localparam int CTRL_W      = 16;
    localparam int LANE_STRIDE = DATA_W / NIB_W;
    localparam int PRE_WR      = 2;
    localparam int POST_WR     = 1;
    localparam int TOTAL_WR    = PRE_WR + NIB_CNT + POST_WR;
    localparam int STEP_W      = $clog2(TOTAL_WR);

    localparam logic [CTRL_W-1:0] CTRL_OPEN0 = 16'hF800;
    localparam logic [CTRL_W-1:0] CTRL_OPEN1 = 16'hF000;
    localparam logic [CTRL_W-1:0] CTRL_DATA  = 16'h0000;
    localparam logic [CTRL_W-1:0] CTRL_CLOSE = 16'hF800;

    // Packed from MSB (bit 23) down to LSB (bit 0).
    typedef struct packed {
        logic       rsv_hi;   // bit 23, must be 1
        logic       src_sel;  // bit 22
        logic       rsv_lo;   // bit 21, must be 0
        logic       clkx_oe;  // bit 20
        logic       clk_oe;   // bit 19
        logic [1:0] vco_div;  // bits 18:17
        logic [1:0] xdiv;     // bits 16:15
        logic       pre_sel;  // bit 14
        logic [6:0] ref_div;  // bits 13:7
        logic [6:0] fb_div;   // bits 6:0
    } pll_word_t;

    // Bits that may be nonzero in a data write: bit 0 of each byte lane.
    function automatic logic [DATA_W-1:0] lane_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NIB_W; i++) m[i*LANE_STRIDE] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pllw_word_pack.sv
// Assembles the control word from its fields.
// Assumes nothing about the reserved inputs: bit 21 is forced to 0 and bit 23 to 1.
module pllw_word_pack
    import pllw_pkg::*;
(
    input  logic [6:0] fb_div,
    input  logic [6:0] ref_div,
    input  logic       pre_sel,
    input  logic [1:0] xdiv,
    input  logic [1:0] vco_div,
    input  logic       clk_oe,
    input  logic       clkx_oe,
    input  logic       src_sel,
    output pll_word_t  word
);
    // Field placement with the reserved bits fixed.
    always_comb begin
        word.fb_div  = fb_div;
        word.ref_div = ref_div;
        word.pre_sel = pre_sel;
        word.xdiv    = xdiv;
        word.vco_div = vco_div;
        word.clk_oe  = clk_oe;
        word.clkx_oe = clkx_oe;
        word.rsv_lo  = 1'b0;
        word.src_sel = src_sel;
        word.rsv_hi  = 1'b1;
    end
endmodule

// File: rtl/pllw_lane_spread.sv
// Spreads a nibble so that bit j goes to bit 0 of byte lane j; all other bits are zero.
// Assumes STRIDE >= 2 and NIB_W * STRIDE == DATA_W.
module pllw_lane_spread #(
    parameter int NIB_W  = 4,
    parameter int STRIDE = 8,
    parameter int DATA_W = NIB_W * STRIDE
) (
    input  logic [NIB_W-1:0]  nib,
    output logic [DATA_W-1:0] data
);
    for (genvar g = 0; g < NIB_W; g++) begin : g_lane
        // One lane: the nibble bit in the lane LSB, zeros above.
        assign data[g*STRIDE +: STRIDE] = {{(STRIDE-1){1'b0}}, nib[g]};
    end
endmodule

// File: rtl/pllw_seq.sv
// Sequencer: captures the word on an idle start and steps through TOTAL_WR write slots,
// one per cycle, then raises done for one cycle. A start pulse while active is ignored.
module pllw_seq
    import pllw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  pll_word_t         word_in,
    output logic              active,
    output logic [STEP_W-1:0] step,
    output pll_word_t         word_q,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_WR - 1);

    // Capture, step counting and the end-of-sequence pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            step   <= '0;
            word_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    step   <= '0;
                    word_q <= word_in;
                end
            end else if (step == LAST_STEP) begin
                active <= 1'b0;
                step   <= '0;
                done   <= 1'b1;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && $past(active)));
    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (step <= LAST_STEP));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start) |=> $stable(word_q));
    assert_reserved_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (word_q.rsv_hi && !word_q.rsv_lo));
endmodule

// File: rtl/pllw_writer.sv
// Top: packs the control word, sequences it and drives one framed write per cycle:
// two opening control writes, NIB_CNT data writes (one nibble each, spread over byte
// lanes) and one closing control write. Assumes start is synchronous to clk.
module pllw_writer
    import pllw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [6:0]        fb_div,
    input  logic [6:0]        ref_div,
    input  logic              pre_sel,
    input  logic [1:0]        xdiv,
    input  logic [1:0]        vco_div,
    input  logic              clk_oe,
    input  logic              clkx_oe,
    input  logic              rsv_lo_in,
    input  logic              src_sel,
    input  logic              rsv_hi_in,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic [CTRL_W-1:0] wr_ctrl,
    output logic              busy,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_WR - 1);
    localparam logic [DATA_W-1:0] LANE_MASK = lane_mask();

    pll_word_t         word_new;
    pll_word_t         word_q;
    logic [WORD_W-1:0] word_bits;
    logic              active;
    logic [STEP_W-1:0] step;
    logic [NIB_W-1:0]  nib;
    logic [DATA_W-1:0] spread;

    // The reserved inputs are accepted at the edge but never used.
    logic unused_rsv;
    assign unused_rsv = rsv_lo_in ^ rsv_hi_in;

    pllw_word_pack u_pack (
        .fb_div  (fb_div),
        .ref_div (ref_div),
        .pre_sel (pre_sel),
        .xdiv    (xdiv),
        .vco_div (vco_div),
        .clk_oe  (clk_oe),
        .clkx_oe (clkx_oe),
        .src_sel (src_sel),
        .word    (word_new)
    );

    pllw_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .word_in (word_new),
        .active  (active),
        .step    (step),
        .word_q  (word_q),
        .done    (done)
    );

    assign word_bits = word_q;

    // Pick the nibble for the current data slot; zero in the framing slots.
    always_comb begin
        nib = '0;
        for (int i = 0; i < NIB_CNT; i++) begin
            if (active && step == STEP_W'(PRE_WR + i)) nib = word_bits[i*NIB_W +: NIB_W];
        end
    end

    pllw_lane_spread #(
        .NIB_W  (NIB_W),
        .STRIDE (LANE_STRIDE),
        .DATA_W (DATA_W)
    ) u_spread (
        .nib  (nib),
        .data (spread)
    );

    // Control value per slot; quiet when idle.
    always_comb begin
        wr_ctrl = CTRL_DATA;
        if (active) begin
            if (step == STEP_W'(0))      wr_ctrl = CTRL_OPEN0;
            else if (step == STEP_W'(1)) wr_ctrl = CTRL_OPEN1;
            else if (step == LAST_STEP)  wr_ctrl = CTRL_CLOSE;
        end
    end

    assign wr_data = spread;
    assign wr_stb  = active;
    assign busy    = active;

    assert_ctrl_write_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_ctrl != CTRL_DATA) |-> (wr_data == '0));
    assert_lane_sparse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ((wr_data & ~LANE_MASK) == '0));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wr_data == '0 && wr_ctrl == '0 && !wr_stb));
    assert_strobe_end_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_stb) |-> done);
    assert_close_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_ctrl) == CTRL_CLOSE);
endmodule

// File: tb/pllw_writer_tb.sv
module pllw_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] pat = '0;
    logic        wr_stb, busy, done;
    logic [31:0] wr_data;
    logic [15:0] wr_ctrl;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    pllw_writer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fb_div    (pat[6:0]),
        .ref_div   (pat[13:7]),
        .pre_sel   (pat[14]),
        .xdiv      (pat[16:15]),
        .vco_div   (pat[18:17]),
        .clk_oe    (pat[19]),
        .clkx_oe   (pat[20]),
        .rsv_lo_in (pat[21]),
        .src_sel   (pat[22]),
        .rsv_hi_in (pat[23]),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_ctrl   (wr_ctrl),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected data for write slot s given the expected word w (R4, R5, R6).
    function automatic logic [31:0] exp_data(input logic [23:0] w, input int s);
        logic [31:0] d;
        d = '0;
        if (s >= 2 && s <= 7)
            for (int j = 0; j < 4; j++) d[8*j] = w[4*(s-2)+j];
        return d;
    endfunction

    function automatic logic [15:0] exp_ctrl(input int s);
        if (s == 0 || s == 8) return 16'hF800;
        if (s == 1) return 16'hF000;
        return 16'h0000;
    endfunction

    // One full sequence for pattern p; optional disturbance mid-run (R8).
    task automatic run_seq(input logic [23:0] p, input bit disturb);
        logic [23:0] w;
        w = p;
        w[21] = 1'b0;   // R2
        w[23] = 1'b1;   // R2
        @(negedge clk);
        pat = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < 9; s++) begin
            if (s > 0) @(negedge clk);
            // R1 R3 R4 R5 R6 R7: strobe, busy, data and control for slot s
            chk($sformatf("R3/R7 slot %0d stb,busy,done", s), {61'd0, wr_stb, busy, done}, 64'b110);
            chk($sformatf("R1/R2/R4/R5/R6 slot %0d data", s), {32'd0, wr_data}, {32'd0, exp_data(w, s)});
            chk($sformatf("R4/R5/R6 slot %0d ctrl", s), {48'd0, wr_ctrl}, {48'd0, exp_ctrl(s)});
            if (disturb && s == 3) begin
                start = 1'b1;
                pat = ~p;
            end
            if (disturb && s == 4) start = 1'b0;
        end
        @(negedge clk);
        chk("R7 done pulse after last write", {61'd0, wr_stb, busy, done}, 64'b001);
        @(negedge clk);
        chk("R7 done single cycle", {63'd0, done}, 64'd0);
        if (disturb) begin
            // R8: no extra strobes after an ignored start
            for (int c = 0; c < 3; c++) begin
                chk("R8 no restart after ignored start", {62'd0, wr_stb, busy}, 64'd0);
                @(negedge clk);
            end
        end
        chk("R9 idle outputs quiet", {wr_data, wr_ctrl, 16'd0}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset stb,busy,done", {61'd0, wr_stb, busy, done}, 64'd0);
        chk("R9 reset data,ctrl", {wr_data, wr_ctrl, 16'd0}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {61'd0, wr_stb, busy, done}, 64'd0);
        // R1 R2: walking one over every field bit
        for (int b = 0; b < 24; b++) run_seq(24'd1 << b, 1'b0);
        run_seq(24'h000000, 1'b0);
        run_seq(24'hFFFFFF, 1'b0);
        // dense arithmetic patterns
        for (int i = 1; i <= 16; i++) run_seq(24'(i * 32'h009E3779 + i), 1'b0);
        // R8: start and field changes during a sequence are ignored
        run_seq(24'h5A3C96, 1'b1);
        run_seq(24'hA5C369, 1'b1);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule